// File: doc/BRIEF.md
# Load-Reserve Reservation Monitor

This block holds the one reservation that a processor pipeline keeps for its load-and-reserve and store-conditional word operations. A reserving load records which 32-byte, 32-byte-aligned granule of memory it touched. A later conditional store to that granule succeeds only if nothing has disturbed the reservation in the meantime. Two events disturb it: a coherence snoop that kills any address inside the held granule, and an external interrupt.

Both operations are also screened for two faults. An effective address that is not word aligned raises an alignment exception. A page that must be written through raises a data storage exception. A faulting operation leaves the reservation exactly as it was. The pipeline presents at most one operation per cycle. Each result appears as a one-cycle pulse in the cycle after the operation, so the condition-register update logic can capture it.

Top module: `lrm_reserve_monitor`

## Requirements
- R1: The granule is the effective address with its low 5 bits dropped, so bits [31:5] are compared. Addresses that differ only in bits [4:0] share one reservation.
- R2: An operation whose address bits [1:0] are not both zero raises `align_exc` for one cycle, in the cycle after the operation. It does not raise `dsi_exc`, and it neither sets nor clears the reservation.
- R3: A word-aligned operation with `page_wt` high raises `dsi_exc` for one cycle, in the cycle after the operation. It leaves the reservation unchanged.
- R4: A conditional store with no fault produces `sc_done` one cycle later. `sc_success` is high only if a valid reservation was held for the store's granule. After reset no reservation is held.
- R5: A snoop kill whose address lies in the held granule clears the reservation. A snoop kill outside the granule has no effect on it.
- R6: `ext_irq` high in any cycle clears the reservation, including one that a reserving load tries to set in that same cycle.
- R7: A reserving load with no fault sets the reservation and replaces any granule held before it.
- R8: Every conditional store with no fault clears the reservation, whether it succeeds or fails.
- R9: If a snoop kill to the held granule and a conditional store arrive in the same cycle, the store fails.
- R10: `sc_success` is never high without `sc_done`. All four outputs are single-cycle pulses tied to one operation, and they are low in cycles that carry no operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_store | input | 1 | 1 = conditional store, 0 = reserving load |
| op_addr | input | 32 | Effective address of the operation |
| page_wt | input | 1 | Target page requires write-through |
| snoop_kill | input | 1 | A reservation-killing snoop is present |
| snoop_addr | input | 32 | Address of the snoop |
| ext_irq | input | 1 | External interrupt is signalled |
| sc_done | output | 1 | Pulse: a conditional store has completed without fault |
| sc_success | output | 1 | Pulse with `sc_done`: that store succeeded |
| align_exc | output | 1 | Pulse: the previous operation was misaligned |
| dsi_exc | output | 1 | Pulse: the previous operation hit a write-through page |

## Verification
The success decision is driven with a store to a different offset in the same granule, which shows that bits [4:0] are ignored. It is also driven with a store one granule away, which shows that bit 5 is compared. Snoops at the last byte of the held granule and at the first byte past it show where the kill boundary lies. Interrupts and a second reserving load to another granule show that the reservation is cleared or replaced. Faulting loads and faulting stores placed between a good load and a good store show that a fault leaves the reservation alone, and a store with a same-cycle kill shows the priority of the kill.

// File: rtl/lrm_pkg.sv
package lrm_pkg;
  localparam int unsigned ADDR_W     = 32;
  localparam int unsigned GRAN_BYTES = 32;
  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned GRAN_LSB   = $clog2(GRAN_BYTES);
  localparam int unsigned WORD_LSB   = $clog2(WORD_BYTES);
  localparam int unsigned TAG_W      = ADDR_W - GRAN_LSB;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [TAG_W-1:0]  tag_t;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_ALIGN   = 2'd1,
    FLT_STORAGE = 2'd2
  } fault_e;

  // Granule tag: the address with the in-granule offset removed.
  function automatic tag_t tag_of(addr_t a);
    return a[ADDR_W-1:GRAN_LSB];
  endfunction

  function automatic logic word_aligned(addr_t a);
    return a[WORD_LSB-1:0] == '0;
  endfunction
endpackage

// File: rtl/lrm_fault_check.sv
module lrm_fault_check
  import lrm_pkg::*;
(
  input  logic   op_valid,
  input  addr_t  op_addr,
  input  logic   page_wt,
  output fault_e fault
);
  // Misalignment is reported ahead of the page attribute.
  always_comb begin
    fault = FLT_NONE;
    if (op_valid) begin
      if (!word_aligned(op_addr))
        fault = FLT_ALIGN;
      else if (page_wt)
        fault = FLT_STORAGE;
    end
  end
endmodule

// File: rtl/lrm_kill_detect.sv
module lrm_kill_detect
  import lrm_pkg::*;
(
  input  logic  res_valid,
  input  tag_t  res_tag,
  input  tag_t  op_tag,
  input  logic  snoop_kill,
  input  addr_t snoop_addr,
  input  logic  ext_irq,
  output logic  kill_held,
  output logic  kill_new
);
  tag_t snoop_tag;
  assign snoop_tag = tag_of(snoop_addr);

  // Kill aimed at the reservation already held.
  assign kill_held = res_valid && (ext_irq || (snoop_kill && snoop_tag == res_tag));
  // Kill aimed at a granule a reserving load is about to take.
  assign kill_new  = ext_irq || (snoop_kill && snoop_tag == op_tag);
endmodule

// File: rtl/lrm_res_keeper.sv
module lrm_res_keeper
  import lrm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load_ok,
  input  logic store_ok,
  input  logic kill_held,
  input  logic kill_new,
  input  tag_t new_tag,
  output logic res_valid,
  output tag_t res_tag
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_tag   <= '0;
    end else if (load_ok) begin
      res_valid <= !kill_new;
      res_tag   <= new_tag;
    end else if (store_ok || kill_held) begin
      res_valid <= 1'b0;
    end
  end

  assert_kill_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (kill_held && !load_ok) |=> !res_valid);

  assert_load_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (load_ok && !kill_new) |=> (res_valid && res_tag == $past(new_tag)));
endmodule

// File: rtl/lrm_reserve_monitor.sv
module lrm_reserve_monitor
  import lrm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic              op_store,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic              page_wt,
  input  logic              snoop_kill,
  input  logic [ADDR_W-1:0] snoop_addr,
  input  logic              ext_irq,
  output logic              sc_done,
  output logic              sc_success,
  output logic              align_exc,
  output logic              dsi_exc
);
  fault_e fault;
  logic   res_valid;
  tag_t   res_tag;
  tag_t   op_tag;
  logic   kill_held, kill_new;
  logic   clean, load_ok, store_ok, pass_now;

  assign op_tag = tag_of(op_addr);

  lrm_fault_check u_fault (
    .op_valid (op_valid),
    .op_addr  (op_addr),
    .page_wt  (page_wt),
    .fault    (fault)
  );

  lrm_kill_detect u_kill (
    .res_valid  (res_valid),
    .res_tag    (res_tag),
    .op_tag     (op_tag),
    .snoop_kill (snoop_kill),
    .snoop_addr (snoop_addr),
    .ext_irq    (ext_irq),
    .kill_held  (kill_held),
    .kill_new   (kill_new)
  );

  assign clean    = op_valid && (fault == FLT_NONE);
  assign load_ok  = clean && !op_store;
  assign store_ok = clean && op_store;
  assign pass_now = store_ok && res_valid && (res_tag == op_tag) && !kill_held;

  lrm_res_keeper u_res (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_ok   (load_ok),
    .store_ok  (store_ok),
    .kill_held (kill_held),
    .kill_new  (kill_new),
    .new_tag   (op_tag),
    .res_valid (res_valid),
    .res_tag   (res_tag)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sc_done    <= 1'b0;
      sc_success <= 1'b0;
      align_exc  <= 1'b0;
      dsi_exc    <= 1'b0;
    end else begin
      sc_done    <= store_ok;
      sc_success <= pass_now;
      align_exc  <= (fault == FLT_ALIGN);
      dsi_exc    <= (fault == FLT_STORAGE);
    end
  end

  assert_fault_keeps_res_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && fault != FLT_NONE && !kill_held) |=> ($stable(res_valid) && $stable(res_tag)));

  assert_exc_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(align_exc && dsi_exc) && !(sc_done && (align_exc || dsi_exc)));

  assert_pass_needs_res_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sc_success |-> $past(res_valid));

  assert_irq_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ext_irq |=> !res_valid);

  assert_store_consumes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    store_ok |=> !res_valid);

  assert_kill_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (store_ok && kill_held) |=> !sc_success);

  assert_strobe_pair_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sc_success |-> sc_done);
endmodule

// File: tb/sim_lrm_reserve_monitor.sv
module sim_lrm_reserve_monitor;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0, op_store = 1'b0, page_wt = 1'b0;
  logic snoop_kill = 1'b0, ext_irq = 1'b0;
  logic [31:0] op_addr = '0, snoop_addr = '0;
  logic sc_done, sc_success, align_exc, dsi_exc;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  lrm_reserve_monitor u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_store(op_store),
    .op_addr(op_addr), .page_wt(page_wt), .snoop_kill(snoop_kill),
    .snoop_addr(snoop_addr), .ext_irq(ext_irq), .sc_done(sc_done),
    .sc_success(sc_success), .align_exc(align_exc), .dsi_exc(dsi_exc)
  );

  typedef struct {
    logic [3:0] v;   // {done, success, align, dsi}
    string      req;
  } exp_t;

  exp_t q[$];

  // Model of the held reservation, written from the requirements.
  logic        m_valid = 1'b0;
  logic [26:0] m_gran  = '0;

  function automatic logic [26:0] gran(logic [31:0] a);
    return a >> 5;
  endfunction

  task automatic step(input int kind, input logic [31:0] a, input logic wt,
                      input logic sk, input logic [31:0] sa, input logic irq,
                      input string req);
    exp_t e;
    logic mis, dsi, ok, held_hit, new_hit, pass;
    @(negedge clk);
    op_valid = (kind != 0); op_store = (kind == 2); op_addr = a; page_wt = wt;
    snoop_kill = sk; snoop_addr = sa; ext_irq = irq;
    mis = (kind != 0) && (a % 4 != 0);
    dsi = (kind != 0) && !mis && wt;
    ok  = (kind != 0) && !mis && !dsi;
    held_hit = m_valid && (irq || (sk && gran(sa) == m_gran));
    new_hit  = irq || (sk && gran(sa) == gran(a));
    pass = ok && kind == 2 && m_valid && gran(a) == m_gran && !held_hit;
    if (ok && kind == 1) begin
      m_valid = !new_hit; m_gran = gran(a);
    end else if ((ok && kind == 2) || held_hit) begin
      m_valid = 1'b0;
    end
    e.v = {ok && kind == 2, pass, mis, dsi};
    e.req = req;
    q.push_back(e);
  endtask

  task automatic idle(input string req);
    step(0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b0, req);
  endtask

  // Monitor: results settle after the edge that follows each driven cycle.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if ({sc_done, sc_success, align_exc, dsi_exc} !== e.v) begin
          errors++;
          $display("FAIL %s: got done/succ/align/dsi=%b expected %b", e.req,
                   {sc_done, sc_success, align_exc, dsi_exc}, e.v);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if ({sc_done, sc_success, align_exc, dsi_exc} !== 4'b0) begin
      errors++;
      $display("FAIL R4 reset: got %b expected 0000", {sc_done, sc_success, align_exc, dsi_exc});
    end
    @(negedge clk); rst_n = 1'b1;

    step(2, 32'h0000_1000, 0, 0, 0, 0, "R4 no reservation after reset");
    step(1, 32'h0000_1000, 0, 0, 0, 0, "R7 load");
    step(2, 32'h0000_101C, 0, 0, 0, 0, "R1 same granule other offset");
    idle("R10 idle after store");
    step(2, 32'h0000_1000, 0, 0, 0, 0, "R8 consumed by success");
    step(1, 32'h0000_1000, 0, 0, 0, 0, "R7 load");
    step(2, 32'h0000_1020, 0, 0, 0, 0, "R1 next granule fails");
    step(2, 32'h0000_1000, 0, 0, 0, 0, "R8 consumed by failure");
    step(1, 32'h0000_2000, 0, 0, 0, 0, "R7 load");
    step(0, 32'h0, 0, 1, 32'h0000_201F, 0, "R5 snoop last byte");
    step(2, 32'h0000_2000, 0, 0, 0, 0, "R5 killed store");
    step(1, 32'h0000_2000, 0, 0, 0, 0, "R7 load");
    step(0, 32'h0, 0, 1, 32'h0000_2020, 0, "R5 snoop outside");
    step(2, 32'h0000_2000, 0, 0, 0, 0, "R5 outside snoop harmless");
    step(1, 32'h0000_3000, 0, 0, 0, 0, "R7 load");
    step(0, 32'h0, 0, 0, 0, 1, "R6 interrupt");
    step(2, 32'h0000_3000, 0, 0, 0, 0, "R6 store after interrupt");
    step(1, 32'h0000_3100, 0, 0, 0, 1, "R6 load with interrupt");
    step(2, 32'h0000_3100, 0, 0, 0, 0, "R6 load killed same cycle");
    step(1, 32'h0000_3000, 0, 0, 0, 0, "R7 first load");
    step(1, 32'h0000_4000, 0, 0, 0, 0, "R7 second load");
    step(2, 32'h0000_3000, 0, 0, 0, 0, "R7 old granule replaced");
    step(1, 32'h0000_4000, 0, 0, 0, 0, "R7 load");
    step(2, 32'h0000_4004, 0, 0, 0, 0, "R7 new granule wins");
    step(1, 32'h0000_5000, 0, 0, 0, 0, "R7 load");
    step(2, 32'h0000_5002, 0, 0, 0, 0, "R2 misaligned store");
    step(2, 32'h0000_5000, 0, 0, 0, 0, "R2 reservation kept");
    step(1, 32'h0000_6000, 0, 0, 0, 0, "R7 load");
    step(1, 32'h0000_7001, 0, 0, 0, 0, "R2 misaligned load");
    step(1, 32'h0000_7003, 1, 0, 0, 0, "R2 alignment over storage");
    step(2, 32'h0000_6000, 0, 0, 0, 0, "R2 no reservation effect");
    step(1, 32'h0000_8000, 1, 0, 0, 0, "R3 write-through load");
    step(2, 32'h0000_8000, 0, 0, 0, 0, "R3 faulting load reserves nothing");
    step(1, 32'h0000_8000, 0, 0, 0, 0, "R7 load");
    step(2, 32'h0000_8000, 1, 0, 0, 0, "R3 write-through store");
    step(2, 32'h0000_8000, 0, 0, 0, 0, "R3 reservation kept");
    step(1, 32'h0000_9000, 0, 0, 0, 0, "R7 load");
    step(2, 32'h0000_9000, 0, 1, 32'h0000_9010, 0, "R9 kill with store");
    step(2, 32'h0000_9000, 0, 0, 0, 0, "R9 cleared after kill");
    idle("R10 quiet");
    idle("R10 quiet");
    repeat (3) @(posedge clk);
    #1;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R10 queue: got %0d pending expected 0", q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule